// File: doc/BRIEF.md
# Maximal Point Detection Engine

This engine takes a batch of two-dimensional points with unsigned X and Y coordinates. It reports, for every point, whether that point is maximal. A point is maximal when no other point in the batch is at least as large in both coordinates. Points stream in one per cycle over a valid/ready port. A batch closes on the beat marked `in_last`, or on the N-th point, whichever comes first.

Once a batch has closed, the engine orders it with an odd-even transposition network of registered slots. The network runs exactly N compare-exchange phases. One pass over the ordered slots then keeps a running maximum of Y and flags the points that exceed it. Results leave in sorted order, one beat per handshake. Each beat carries the coordinates, the position at which the point arrived, and the maximal flag. A one-cycle completion pulse follows the last beat.

Back-pressure rules:
- The input side is refused (`in_ready` low) from the moment the batch closes until the completion pulse is over.
- The output side holds each beat, unchanged, until `out_ready` takes it.

Behaviour is defined only for batches without two identical points.

Top module: `maxpt_engine`

## Requirements
- R1: After reset, `in_ready` is 1, and `out_valid` and `batch_done` are both 0.
- R2: A point is taken on a cycle with `in_valid` and `in_ready` both high. Its index is its arrival position within the batch, counted from 0. The batch closes on the beat with `in_last` high, or on the N-th point.
- R3: `in_ready` stays low from the cycle after the closing point is taken until the cycle after `batch_done`. Points offered during that time are not taken. `in_ready` is never high while `out_valid` is high.
- R4: Output beats come in descending X order, and points with equal X come in descending Y order.
- R5: `out_max` is 1 exactly when `out_y` is strictly greater than every Y already emitted in the batch. The first beat of a batch always has `out_max` = 1.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and every output field stay unchanged on the next cycle.
- R7: A batch of k points produces exactly k beats. `batch_done` is high for exactly one cycle, the cycle after the last beat is taken, and `out_valid` is low during that cycle.
- R8: The first `out_valid` of a batch appears N clock edges after the edge on which the closing point is taken.
- R9: A batch of a single point produces one beat with `out_max` = 1 and `out_idx` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input point offered |
| in_ready | output | 1 | Engine accepts a point |
| in_x | input | XW | X coordinate of the offered point |
| in_y | input | YW | Y coordinate of the offered point |
| in_last | input | 1 | Offered point closes the batch |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_x | output | XW | X coordinate of the beat |
| out_y | output | YW | Y coordinate of the beat |
| out_idx | output | IW | Arrival index of the beat's point |
| out_max | output | 1 | Beat's point is maximal |
| batch_done | output | 1 | One-cycle pulse after the last beat of a batch |

## Verification
The assertions check four behaviours on every cycle:
- the handshake separation between input and output;
- beat stability under back-pressure;
- descending two-key order between consecutive beats;
- the strict-greater flag against a running maximum held by the checker, with the forced flag on each first beat, and the shape of the completion pulse.

Only the bench's scenarios can show the rest. That covers whether the set of flagged points matches a brute-force dominance search, and whether arrival indices are carried through the sort. It also covers the fixed N-edge sort latency, batches closed by count versus by `in_last`, and the refusal of points offered while a batch is busy.

// File: rtl/maxpt_pkg.sv
package maxpt_pkg;
  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_SORT = 2'd1,
    ST_SCAN = 2'd2,
    ST_DONE = 2'd3
  } eng_state_e;
endpackage

// File: rtl/maxpt_order.sv
// Decides whether point A must precede point B in output order:
// occupied slots first, then larger X, then larger Y.
module maxpt_order #(
  parameter int XW = 8,
  parameter int YW = 8
) (
  input  logic          a_vld,
  input  logic [XW-1:0] a_x,
  input  logic [YW-1:0] a_y,
  input  logic          b_vld,
  input  logic [XW-1:0] b_x,
  input  logic [YW-1:0] b_y,
  output logic          a_first
);
  logic key_gt;

  always_comb begin
    key_gt = (a_x > b_x) || ((a_x == b_x) && (a_y > b_y));
    if (a_vld && !b_vld)       a_first = 1'b1;
    else if (!a_vld)           a_first = 1'b0;
    else                       a_first = key_gt;
  end
endmodule

// File: rtl/maxpt_sorter.sv
// Registered slot array with an odd-even transposition network.
// Each step applies the compare-exchange cells of one parity.
module maxpt_sorter #(
  parameter int N  = 8,
  parameter int XW = 8,
  parameter int YW = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_pos,
  input  logic [XW-1:0] ld_x,
  input  logic [YW-1:0] ld_y,
  input  logic          step,
  input  logic          odd_phase,
  input  logic [IW-1:0] rd_pos,
  output logic [XW-1:0] rd_x,
  output logic [YW-1:0] rd_y,
  output logic [IW-1:0] rd_idx
);
  logic [N-1:0]  vld_q;
  logic [XW-1:0] x_q   [N];
  logic [YW-1:0] y_q   [N];
  logic [IW-1:0] idx_q [N];

  logic [N-1:0]  vld_n;
  logic [XW-1:0] x_n   [N];
  logic [YW-1:0] y_n   [N];
  logic [IW-1:0] idx_n [N];

  logic [N-1:0]  swap;

  // Compare-exchange cells, one per adjacent pair.
  for (genvar i = 0; i < N - 1; i++) begin : g_pair
    logic hi_first;
    maxpt_order #(.XW(XW), .YW(YW)) u_ord (
      .a_vld  (vld_q[i+1]),
      .a_x    (x_q[i+1]),
      .a_y    (y_q[i+1]),
      .b_vld  (vld_q[i]),
      .b_x    (x_q[i]),
      .b_y    (y_q[i]),
      .a_first(hi_first)
    );
    assign swap[i] = step && (odd_phase == ((i % 2) == 1)) && hi_first;
  end
  assign swap[N-1] = 1'b0;

  // Next value of every slot: from above, from below, or kept.
  for (genvar j = 0; j < N; j++) begin : g_slot
    logic          from_hi, from_lo;
    logic          up_v, dn_v;
    logic [XW-1:0] up_x, dn_x;
    logic [YW-1:0] up_y, dn_y;
    logic [IW-1:0] up_i, dn_i;

    if (j < N - 1) begin : g_up
      assign from_hi = swap[j];
      assign up_v    = vld_q[j+1];
      assign up_x    = x_q[j+1];
      assign up_y    = y_q[j+1];
      assign up_i    = idx_q[j+1];
    end else begin : g_up_edge
      assign from_hi = 1'b0;
      assign up_v    = vld_q[j];
      assign up_x    = x_q[j];
      assign up_y    = y_q[j];
      assign up_i    = idx_q[j];
    end

    if (j > 0) begin : g_dn
      assign from_lo = swap[j-1];
      assign dn_v    = vld_q[j-1];
      assign dn_x    = x_q[j-1];
      assign dn_y    = y_q[j-1];
      assign dn_i    = idx_q[j-1];
    end else begin : g_dn_edge
      assign from_lo = 1'b0;
      assign dn_v    = vld_q[j];
      assign dn_x    = x_q[j];
      assign dn_y    = y_q[j];
      assign dn_i    = idx_q[j];
    end

    assign vld_n[j] = from_hi ? up_v : (from_lo ? dn_v : vld_q[j]);
    assign x_n[j]   = from_hi ? up_x : (from_lo ? dn_x : x_q[j]);
    assign y_n[j]   = from_hi ? up_y : (from_lo ? dn_y : y_q[j]);
    assign idx_n[j] = from_hi ? up_i : (from_lo ? dn_i : idx_q[j]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int k = 0; k < N; k++) begin
        x_q[k]   <= '0;
        y_q[k]   <= '0;
        idx_q[k] <= '0;
      end
    end else if (clr) begin
      vld_q <= '0;
    end else begin
      for (int k = 0; k < N; k++) begin
        if (ld_en && (ld_pos == IW'(k))) begin
          vld_q[k] <= 1'b1;
          x_q[k]   <= ld_x;
          y_q[k]   <= ld_y;
          idx_q[k] <= ld_pos;
        end else begin
          vld_q[k] <= vld_n[k];
          x_q[k]   <= x_n[k];
          y_q[k]   <= y_n[k];
          idx_q[k] <= idx_n[k];
        end
      end
    end
  end

  assign rd_x   = x_q[rd_pos];
  assign rd_y   = y_q[rd_pos];
  assign rd_idx = idx_q[rd_pos];
endmodule

// File: rtl/maxpt_scan.sv
// Running prefix maximum over Y in emission order; flags strict gains.
module maxpt_scan #(
  parameter int YW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          fire,
  input  logic [YW-1:0] cur_y,
  output logic          is_max
);
  logic          seen_q;
  logic [YW-1:0] run_q;

  // "Nothing seen yet" acts as a maximum below every legal Y.
  assign is_max = !seen_q || (cur_y > run_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      run_q  <= '0;
    end else if (clr) begin
      seen_q <= 1'b0;
      run_q  <= '0;
    end else if (fire) begin
      seen_q <= 1'b1;
      if (is_max) run_q <= cur_y;
    end
  end
endmodule

// File: rtl/maxpt_engine.sv
module maxpt_engine #(
  parameter int N  = 8,
  parameter int XW = 8,
  parameter int YW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [XW-1:0] in_x,
  input  logic [YW-1:0] in_y,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [XW-1:0] out_x,
  output logic [YW-1:0] out_y,
  output logic [IW-1:0] out_idx,
  output logic          out_max,
  output logic          batch_done
);
  import maxpt_pkg::*;

  localparam int CW = $clog2(N + 1);

  eng_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] ph_q;
  logic [IW-1:0] pos_q;

  logic in_fire, out_fire, sorting, clr_all, close_batch, last_beat;

  assign in_ready    = (state_q == ST_LOAD);
  assign out_valid   = (state_q == ST_SCAN);
  assign batch_done  = (state_q == ST_DONE);
  assign sorting     = (state_q == ST_SORT);
  assign clr_all     = (state_q == ST_DONE);
  assign in_fire     = in_valid && in_ready;
  assign out_fire    = out_valid && out_ready;
  assign close_batch = in_last || (cnt_q == CW'(N - 1));
  assign last_beat   = (CW'(pos_q) == (cnt_q - CW'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_LOAD;
      cnt_q   <= '0;
      ph_q    <= '0;
      pos_q   <= '0;
    end else begin
      case (state_q)
        ST_LOAD: if (in_fire) begin
          cnt_q <= cnt_q + CW'(1);
          if (close_batch) begin
            state_q <= ST_SORT;
            ph_q    <= '0;
          end
        end
        ST_SORT: begin
          ph_q <= ph_q + IW'(1);
          if (ph_q == IW'(N - 1)) begin
            state_q <= ST_SCAN;
            pos_q   <= '0;
          end
        end
        ST_SCAN: if (out_fire) begin
          pos_q <= pos_q + IW'(1);
          if (last_beat) state_q <= ST_DONE;
        end
        default: begin
          state_q <= ST_LOAD;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  maxpt_sorter #(.N(N), .XW(XW), .YW(YW), .IW(IW)) u_sort (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_all),
    .ld_en    (in_fire),
    .ld_pos   (cnt_q[IW-1:0]),
    .ld_x     (in_x),
    .ld_y     (in_y),
    .step     (sorting),
    .odd_phase(ph_q[0]),
    .rd_pos   (pos_q),
    .rd_x     (out_x),
    .rd_y     (out_y),
    .rd_idx   (out_idx)
  );

  maxpt_scan #(.YW(YW)) u_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_all),
    .fire  (out_fire),
    .cur_y (out_y),
    .is_max(out_max)
  );
endmodule

// File: rtl/maxpt_engine_chk.sv
module maxpt_engine_chk #(
  parameter int N  = 8,
  parameter int XW = 8,
  parameter int YW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [XW-1:0] in_x,
  input logic [YW-1:0] in_y,
  input logic          in_last,
  input logic          out_valid,
  input logic          out_ready,
  input logic [XW-1:0] out_x,
  input logic [YW-1:0] out_y,
  input logic [IW-1:0] out_idx,
  input logic          out_max,
  input logic          batch_done
);
  logic          seen;
  logic [XW-1:0] prev_x;
  logic [YW-1:0] prev_y;
  logic [YW-1:0] top_y;

  always_ff @(posedge clk) begin
    if (!rst_n || batch_done) begin
      seen   <= 1'b0;
      prev_x <= '0;
      prev_y <= '0;
      top_y  <= '0;
    end else if (out_valid && out_ready) begin
      seen   <= 1'b1;
      prev_x <= out_x;
      prev_y <= out_y;
      if (!seen || out_y > top_y) top_y <= out_y;
    end
  end

  p_sides_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_beat_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_y)
                                   && $stable(out_idx) && $stable(out_max)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    batch_done |=> (!batch_done && in_ready));

  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    batch_done |-> !out_valid);

  p_first_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !seen) |-> out_max);

  p_strict_gain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen) |-> (out_max == (out_y > top_y)));

  p_descending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen) |-> ((out_x < prev_x) || ((out_x == prev_x) && (out_y < prev_y))));
endmodule

bind maxpt_engine maxpt_engine_chk #(.N(N), .XW(XW), .YW(YW)) u_chk (.*);

// File: tb/maxpt_engine_test.sv
`timescale 1ns/1ps
module maxpt_engine_test;
  localparam int N  = 8;
  localparam int XW = 8;
  localparam int YW = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [XW-1:0] in_x = '0;
  logic [YW-1:0] in_y = '0;
  logic          in_last = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [XW-1:0] out_x;
  logic [YW-1:0] out_y;
  logic [IW-1:0] out_idx;
  logic          out_max;
  logic          batch_done;

  int checks = 0;
  int errors = 0;

  int qx[$];
  int qy[$];

  always #4 clk = ~clk;

  maxpt_engine #(.N(N), .XW(XW), .YW(YW)) uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic bit has_pt(input int x, input int y);
    foreach (qx[k]) if (qx[k] == x && qy[k] == y) return 1'b1;
    return 1'b0;
  endfunction

  task automatic add_pt(input int x, input int y);
    qx.push_back(x);
    qy.push_back(y);
  endtask

  // Runs one batch from qx/qy against a behavioural model.
  task automatic run_batch(input bit use_last, input bit bp);
    int n;
    int ord[$];
    bit flag[$];
    int b, lat;
    bit held;
    n = qx.size();
    // Expected order: X descending, then Y descending (R4).
    for (int i = 0; i < n; i++) ord.push_back(i);
    for (int i = 0; i < n; i++) begin
      for (int j = i + 1; j < n; j++) begin
        if (qx[ord[j]] > qx[ord[i]] ||
            (qx[ord[j]] == qx[ord[i]] && qy[ord[j]] > qy[ord[i]])) begin
          int t = ord[i];
          ord[i] = ord[j];
          ord[j] = t;
        end
      end
    end
    // Brute-force dominance: maximal iff no other point >= in both (R5).
    for (int i = 0; i < n; i++) begin
      bit dom = 1'b0;
      for (int j = 0; j < n; j++)
        if (j != ord[i] && qx[j] >= qx[ord[i]] && qy[j] >= qy[ord[i]]) dom = 1'b1;
      flag.push_back(!dom);
    end

    // Load (R2).
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_x     = XW'(qx[i]);
      in_y     = YW'(qy[i]);
      in_last  = use_last && (i == n - 1);
      chk(in_ready == 1'b1, "R2", "in_ready during load", int'(in_ready), 1);
      tick();
    end
    // Offer junk while busy (R3).
    in_valid = 1'b1;
    in_x     = 8'hFF;
    in_y     = 8'hFF;
    in_last  = 1'b1;
    lat = 0;
    while (!out_valid && lat < 4 * N) begin
      chk(in_ready == 1'b0, "R3", "in_ready while sorting", int'(in_ready), 0);
      tick();
      lat++;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    chk(lat == N, "R8", "edges to first out_valid", lat, N);

    b = 0;
    held = 1'b0;
    while (b < n && lat < 4000) begin
      out_ready = bp ? 1'($urandom_range(0, 1)) : 1'b1;
      chk(out_valid == 1'b1, held ? "R6" : "R7", "out_valid", int'(out_valid), 1);
      chk(in_ready == 1'b0, "R3", "in_ready while scanning", int'(in_ready), 0);
      chk(out_x == XW'(qx[ord[b]]), "R4", "out_x", int'(out_x), qx[ord[b]]);
      chk(out_y == YW'(qy[ord[b]]), "R4", "out_y", int'(out_y), qy[ord[b]]);
      chk(out_idx == IW'(ord[b]), "R2", "out_idx", int'(out_idx), ord[b]);
      chk(out_max == flag[b], n == 1 ? "R9" : "R5", "out_max", int'(out_max), int'(flag[b]));
      held = !out_ready;
      if (out_ready) b++;
      tick();
      lat++;
    end
    out_ready = 1'b0;
    chk(batch_done == 1'b1, "R7", "batch_done after last beat", int'(batch_done), 1);
    chk(out_valid == 1'b0, "R7", "no extra beat", int'(out_valid), 0);
    tick();
    chk(batch_done == 1'b0, "R7", "batch_done width", int'(batch_done), 0);
    chk(in_ready == 1'b1, "R3", "in_ready after done", int'(in_ready), 1);
    qx.delete();
    qy.delete();
  endtask

  task automatic rand_batch(input int n);
    while (qx.size() < n) begin
      int x = $urandom_range(0, 40);
      int y = $urandom_range(0, 40);
      if (!has_pt(x, y)) add_pt(x, y);
    end
  endtask

  initial begin
    repeat (3) tick();
    chk(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(batch_done == 1'b0, "R1", "batch_done in reset", int'(batch_done), 0);
    rst_n = 1'b1;
    tick();
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // Full batch closed by count (R2).
    rand_batch(N);
    run_batch(1'b0, 1'b0);
    // Short batch closed by in_last, with back-pressure (R6).
    rand_batch(5);
    run_batch(1'b1, 1'b1);
    // Single point (R9).
    add_pt(17, 3);
    run_batch(1'b1, 1'b0);
    // Staircase: every point maximal.
    for (int i = 0; i < 6; i++) add_pt(i * 10, 100 - i * 10);
    run_batch(1'b1, 1'b1);
    // Chain: only the top point maximal.
    for (int i = 0; i < 5; i++) add_pt(i + 2, i + 2);
    run_batch(1'b1, 1'b0);
    // Equal X columns with the strict Y rule.
    add_pt(5, 1); add_pt(5, 9); add_pt(5, 4); add_pt(3, 20); add_pt(7, 0);
    run_batch(1'b1, 1'b1);
    // Random sizes with random back-pressure.
    for (int r = 0; r < 12; r++) begin
      int n = $urandom_range(1, N);
      rand_batch(n);
      run_batch(n != N, 1'b1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule